// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block models a synchronous burst SRAM of four byte lanes. Address, write data, chip selects, the two address strobes, the burst advance input and the write enables are all taken at the rising clock edge. One of five cycle types is decoded from them on every edge. A new burst may start from either strobe. A burst then walks the low two address bits through a two-bit counter, and that counter can run in linear or interleaved order. Between bursts the chip can be deselected.

Read data leaves on a separate output bus with a drive-enable flag, which stands in for a bidirectional bus. A static mode input selects one of two output paths: flow-through, where data follows the capturing edge, or pipelined, where one output register adds a cycle. In pipelined mode, a deselect or write gives up the bus one stage ahead of where read data would sit. An active-low output enable gates the drivers asynchronously. A sleep input freezes all activity and keeps the array contents.

Top module: `sync_burst_sram`

## Requirements
- R1: The chip counts as selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0, and the selects are only looked at on a cycle that takes a strobe. A strobe cycle that is not selected is a deselect: nothing is written, the outputs are released, and the burst in progress ends.
- R2: A low `strobe_p_n` while `ce1_n` is high is ignored. The cycle then acts exactly as if both strobes were high, so it continues or suspends the burst in progress.
- R3: A selected cycle with `strobe_p_n` low starts a read burst at `addr` and writes nothing, whatever the write inputs say.
- R4: A selected cycle with `strobe_p_n` high and `strobe_c_n` low starts a burst at `addr`. It is a write if the write inputs call for one and a read otherwise.
- R5: With both strobes high, `adv_n`=0 moves to the next burst address and `adv_n`=1 stays on the current one. Each such cycle reads or writes according to its own write inputs. When no burst is in progress, such a cycle makes no access.
- R6: Burst access k (k=0..3, start s = `addr[1:0]`) uses the low address bits (s+k) mod 4 when `lin_order_n`=0 and s XOR k when it is 1. The upper address bits stay fixed, and the fifth access returns to s.
- R7: `gw_n`=0 writes all lanes. Otherwise `bwe_n`=0 writes only each lane i whose `lane_we_n[i]`=0. Lane i is `din[9i+8:9i]`. Any other combination, including `bwe_n`=0 with all lane enables high, is a read.
- R8: A read drives all 36 bits. A write cycle puts no drive into its own output slot.
- R9: With `pipe_mode`=0, a read captured at edge k drives its data with `dout_en`=1 from edge k until edge k+1.
- R10: With `pipe_mode`=1, a read captured at edge k drives its data from edge k+1 until edge k+2. If the cycle at k+1 is a deselect or a write, the drive ends at edge k+2.
- R11: `oe_n`=1 clears `dout_en` at once, without waiting for a clock. `oe_n`=0 only passes a drive that a read has already set up.
- R12: While `sleep`=1, edges cause no write, no read and no change to the burst state, and `dout_en` is 0. The stored contents survive the sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, low two bits preset the burst counter |
| din | input | 36 | Write data, four 9-bit lanes |
| ce1_n | input | 1 | Chip select, active low, also masks strobe P |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| strobe_p_n | input | 1 | Address strobe P, active low, always starts a read |
| strobe_c_n | input | 1 | Address strobe C, active low, starts a read or write |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 1 selects the pipelined path, 0 flow-through |
| lin_order_n | input | 1 | 0 selects linear burst order, 1 interleaved |
| sleep | input | 1 | Standby with data retention, active high |
| dout | output | 36 | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable |

## Verification
A burst counter that is wrong does not show up as an error flag. It shows as correct-looking data from a neighbouring word of the same four-word group, on the first advance in flow-through mode and one cycle later in pipelined mode. For that reason every read is compared against a reference memory that the bench fills with distinct per-lane patterns. A stale activity flag in the output stage shows up as `dout_en` staying high one slot too long after a deselect, a write or sleep, so the drive flag is sampled in the slot right after each such cycle. A write mask that is wrong only shows on a later read of the merged word, and that read is always done.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Cycle type decoded from one clock's control inputs
  typedef enum logic [2:0] {
    OP_IDLE,   // no activity (sleep)
    OP_DESEL,  // strobe taken with chip not selected
    OP_START,  // new burst from the external address
    OP_NEXT,   // advance the burst counter
    OP_HOLD    // stay on the current burst address
  } op_e;

  // Low two address bits for burst step 'step' from start 'start'
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       linear);
    logic [1:0] r;
    if (linear) r = start + step;
    else        r = start ^ step;
    return r;
  endfunction

endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             strobe_p_n,
  input  logic             strobe_c_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             sleep,
  output op_e              op,
  output logic [LANES-1:0] lane_mask
);

  logic             selected;
  logic             p_taken;
  logic [LANES-1:0] wr_mask;

  always_comb begin
    selected = ~ce1_n & ce2 & ~ce3_n;
    // strobe P is masked by ce1_n high
    p_taken  = ~strobe_p_n & ~ce1_n;

    if (!gw_n)       wr_mask = '1;
    else if (!bwe_n) wr_mask = ~lane_we_n;
    else             wr_mask = '0;

    op        = OP_IDLE;
    lane_mask = '0;
    if (sleep) begin
      op        = OP_IDLE;
    end else if (p_taken) begin
      op        = selected ? OP_START : OP_DESEL;
    end else if (!strobe_c_n) begin
      op        = selected ? OP_START : OP_DESEL;
      lane_mask = selected ? wr_mask : '0;
    end else begin
      op        = adv_n ? OP_HOLD : OP_NEXT;
      lane_mask = wr_mask;
    end
  end

endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              linear,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_valid
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        step_q, step_d;
  logic              live_q, live_d;
  logic [1:0]        step_nx;

  always_comb begin
    base_d    = base_q;
    step_d    = step_q;
    live_d    = live_q;
    acc_valid = 1'b0;
    acc_addr  = base_q;
    step_nx   = step_q + 2'd1;
    case (op)
      OP_START: begin
        base_d    = addr;
        step_d    = 2'd0;
        live_d    = 1'b1;
        acc_valid = 1'b1;
        acc_addr  = addr;
      end
      OP_NEXT: begin
        if (live_q) begin
          step_d    = step_nx;
          acc_valid = 1'b1;
          acc_addr  = {base_q[ADDR_W-1 -: HI_W], burst_low(base_q[1:0], step_nx, linear)};
        end
      end
      OP_HOLD: begin
        if (live_q) begin
          acc_valid = 1'b1;
          acc_addr  = {base_q[ADDR_W-1 -: HI_W], burst_low(base_q[1:0], step_q, linear)};
        end
      end
      OP_DESEL: live_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      live_q <= 1'b0;
    end else begin
      base_q <= base_d;
      step_q <= step_d;
      live_q <= live_d;
    end
  end

  // R5
  desel_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DESEL) |=> !(acc_valid && (op != OP_START)));

  // R6
  next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NEXT && acc_valid) |=> (step_q == $past(step_q) + 2'd1));

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_mask[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              pipe_mode,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              ft_act_q, ft_act_d;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic              pipe_act_q, pipe_act_d;
  logic [DATA_W-1:0] pipe_data_q, pipe_data_d;
  logic              drive;

  always_comb begin
    ft_act_d    = acc_rd;
    rd_addr_d   = acc_rd ? acc_addr : rd_addr_q;
    // single-cycle deselect: the slot after a non-read is empty
    pipe_act_d  = ft_act_q;
    pipe_data_d = ft_act_q ? arr_data : pipe_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_act_q    <= 1'b0;
      rd_addr_q   <= '0;
      pipe_act_q  <= 1'b0;
      pipe_data_q <= '0;
    end else begin
      ft_act_q    <= ft_act_d;
      rd_addr_q   <= rd_addr_d;
      pipe_act_q  <= pipe_act_d;
      pipe_data_q <= pipe_data_d;
    end
  end

  always_comb begin
    drive   = pipe_mode ? pipe_act_q : ft_act_q;
    dout_en = drive & ~oe_n & ~sleep;
    if (dout_en) dout = pipe_mode ? pipe_data_q : arr_data;
    else         dout = '0;
  end

  assign rd_addr = rd_addr_q;

  // R9
  flow_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && dout_en) |-> $past(acc_rd));

  // R10
  pipe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && dout_en) |-> $past(acc_rd, 2));

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    strobe_p_n,
  input  logic                    strobe_c_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic                    pipe_mode,
  input  logic                    lin_order_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DATA_W = LANES * LANE_W;

  op_e               op;
  logic [LANES-1:0]  lane_mask;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_valid;
  logic [LANES-1:0]  arr_we;
  logic              acc_rd;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] arr_data;

  sbs_cycle_decode #(.LANES(LANES)) u_dec (
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .adv_n      (adv_n),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .lane_we_n  (lane_we_n),
    .sleep      (sleep),
    .op         (op),
    .lane_mask  (lane_mask)
  );

  sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .addr      (addr),
    .linear    (~lin_order_n),
    .acc_addr  (acc_addr),
    .acc_valid (acc_valid)
  );

  assign arr_we = acc_valid ? lane_mask : '0;
  assign acc_rd = acc_valid & ~(|lane_mask);

  sbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .we_mask (arr_we),
    .wr_addr (acc_addr),
    .wr_data (din),
    .rd_addr (rd_addr),
    .rd_data (arr_data)
  );

  sbs_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_rd    (acc_rd),
    .acc_addr  (acc_addr),
    .arr_data  (arr_data),
    .pipe_mode (pipe_mode),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .rd_addr   (rd_addr),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  // R3
  strobe_p_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_p_n && !ce1_n) |-> (arr_we == '0));

  // R7
  global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && !sleep && acc_valid && !(!strobe_p_n && !ce1_n)) |-> (&arr_we));

  // R8
  write_slot_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && (|arr_we)) |=> !dout_en);

  // R12
  sleep_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (arr_we == '0));

endmodule

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic [35:0] din;
  logic        ce1_n, ce2, ce3_n, strobe_p_n, strobe_c_n, adv_n;
  logic        gw_n, bwe_n, oe_n, pipe_mode, lin_order_n, sleep;
  logic [3:0]  lane_we_n;
  logic [35:0] dout;
  logic        dout_en;

  int   total = 0;
  int   bad   = 0;
  bit   ended = 0;
  logic [35:0] ref_mem [256];

  always #4 clk = ~clk;  // 125 MHz

  sync_burst_sram dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .oe_n(oe_n),
    .pipe_mode(pipe_mode), .lin_order_n(lin_order_n), .sleep(sleep),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string tag, input logic exp_en, input logic [35:0] exp_d);
    total++;
    if (dout_en !== exp_en || (exp_en && dout !== exp_d)) begin
      bad++;
      $display("FAIL %s: en=%b data=%h expected en=%b data=%h",
               tag, dout_en, dout, exp_en, exp_en ? exp_d : 36'h0);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  // deselect cycle: strobe C taken with ce1_n high
  task automatic quiet();
    strobe_p_n = 1; strobe_c_n = 0; ce1_n = 1; ce2 = 1; ce3_n = 0;
    adv_n = 1; gw_n = 1; bwe_n = 1; lane_we_n = 4'hF; din = '0; addr = '0;
  endtask

  task automatic start_c(input logic [7:0] a);
    strobe_p_n = 1; strobe_c_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; addr = a;
  endtask

  task automatic start_p(input logic [7:0] a);
    strobe_p_n = 0; strobe_c_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0; addr = a;
  endtask

  task automatic go_on(input logic hold);
    strobe_p_n = 1; strobe_c_n = 1; adv_n = hold;
  endtask

  task automatic as_write(input logic [35:0] d, input logic g, input logic b, input logic [3:0] l);
    din = d; gw_n = g; bwe_n = b; lane_we_n = l;
  endtask

  task automatic as_read();
    gw_n = 1; bwe_n = 1; lane_we_n = 4'hF;
  endtask

  task automatic ref_write(input logic [7:0] a, input logic [35:0] d,
                           input logic g, input logic b, input logic [3:0] l);
    for (int i = 0; i < 4; i++) begin
      if (!g || (!b && !l[i])) ref_mem[a][i*9 +: 9] = d[i*9 +: 9];
    end
  endtask

  function automatic logic [7:0] seq(input logic [7:0] base, input int k, input bit lin);
    logic [1:0] kk;
    logic [1:0] lo;
    kk = k[1:0];
    lo = lin ? base[1:0] + kk : base[1:0] ^ kk;
    return {base[7:2], lo};
  endfunction

  function automatic logic [35:0] pat(input int k);
    return {9'h100 + 9'(k), 9'h0A5, 9'h15A ^ 9'(k), 9'h0C3 + 9'(k)};
  endfunction

  task automatic t_reset();
    check("R9 R10 reset leaves outputs off", 1'b0, '0);
  endtask

  task automatic t_single();
    quiet(); cyc();
    start_c(8'h20); as_write(36'h123456789, 0, 1, 4'hF); cyc();
    ref_write(8'h20, 36'h123456789, 0, 1, 4'hF);
    check("R8 write slot undriven", 1'b0, '0);
    start_c(8'h20); as_read(); cyc();
    check("R4 R9 strobe-C read flow-through", 1'b1, ref_mem[8'h20]);
    quiet(); cyc();
    check("R1 deselect releases outputs", 1'b0, '0);
  endtask

  task automatic t_linear_burst();
    logic [7:0] b = 8'h35;
    start_c(b); as_write(pat(0), 0, 1, 4'hF); cyc(); ref_write(seq(b, 0, 1), pat(0), 0, 1, 4'hF);
    for (int i = 1; i < 4; i++) begin
      go_on(0); as_write(pat(i), 0, 1, 4'hF); cyc();
      ref_write(seq(b, i, 1), pat(i), 0, 1, 4'hF);
    end
    quiet(); cyc();
    start_p(b); as_write(36'hFFFFFFFFF, 0, 0, 4'h0); cyc();
    check("R3 strobe-P starts read despite write inputs", 1'b1, ref_mem[b]);
    for (int i = 1; i < 5; i++) begin
      go_on(0); as_read(); cyc();
      check("R5 R6 linear burst order and wrap", 1'b1, ref_mem[seq(b, i, 1)]);
    end
    quiet(); cyc();
  endtask

  task automatic t_interleave();
    lin_order_n = 1;
    for (int i = 0; i < 4; i++) begin
      start_c(8'h40 + 8'(i)); as_write(pat(10 + i), 0, 1, 4'hF); cyc();
      ref_write(8'h40 + 8'(i), pat(10 + i), 0, 1, 4'hF);
    end
    quiet(); cyc();
    start_c(8'h42); as_read(); cyc();
    check("R6 interleaved first access", 1'b1, ref_mem[8'h42]);
    for (int i = 1; i < 4; i++) begin
      go_on(0); cyc();
      check("R6 interleaved order", 1'b1, ref_mem[seq(8'h42, i, 0)]);
    end
    quiet(); cyc();
    lin_order_n = 0;
  endtask

  task automatic t_bytes();
    logic [35:0] d = {9'h1AA, 9'h155, 9'h0F0, 9'h00F};
    start_c(8'h20); as_write(d, 1, 0, 4'b1010); cyc();
    ref_write(8'h20, d, 1, 0, 4'b1010);
    start_c(8'h20); as_read(); cyc();
    check("R7 only lanes 0 and 2 written", 1'b1, ref_mem[8'h20]);
    start_c(8'h20); as_write(36'h0DEADBEEF, 1, 0, 4'hF); cyc();
    check("R7 byte enable with no lanes reads", 1'b1, ref_mem[8'h20]);
    start_c(8'h20); as_write(36'h987654321, 0, 0, 4'hF); cyc();
    ref_write(8'h20, 36'h987654321, 0, 0, 4'hF);
    check("R8 global write slot undriven", 1'b0, '0);
    start_c(8'h20); as_read(); cyc();
    check("R7 global write overrides lane enables", 1'b1, ref_mem[8'h20]);
    quiet(); cyc();
  endtask

  task automatic t_suspend();
    start_c(8'h50); as_write(pat(20), 0, 1, 4'hF); cyc(); ref_write(8'h50, pat(20), 0, 1, 4'hF);
    go_on(1); as_write(pat(21), 0, 1, 4'hF); cyc(); ref_write(8'h50, pat(21), 0, 1, 4'hF);
    start_c(8'h51); as_write(pat(22), 0, 1, 4'hF); cyc(); ref_write(8'h51, pat(22), 0, 1, 4'hF);
    quiet(); cyc();
    start_c(8'h50); as_read(); cyc();
    check("R5 suspended write stayed on address", 1'b1, ref_mem[8'h50]);
    go_on(1); cyc();
    check("R5 suspend read repeats address", 1'b1, ref_mem[8'h50]);
    go_on(0); cyc();
    check("R5 advance after suspend", 1'b1, ref_mem[8'h51]);
    quiet(); cyc();
  endtask

  task automatic t_strobe_mask();
    start_c(8'h40); as_read(); cyc();
    check("R4 burst start", 1'b1, ref_mem[8'h40]);
    strobe_p_n = 0; strobe_c_n = 1; ce1_n = 1; adv_n = 0; addr = 8'h99; cyc();
    check("R2 masked strobe-P continues burst", 1'b1, ref_mem[8'h41]);
    start_p(8'h20); ce2 = 0; as_write(36'h0AAAAAAAA, 0, 1, 4'hF); cyc();
    check("R1 ce2 low deselects", 1'b0, '0);
    go_on(0); as_read(); cyc();
    check("R5 no access after deselect", 1'b0, '0);
    start_c(8'h20); ce3_n = 1; as_write(36'h0BBBBBBBB, 0, 1, 4'hF); cyc();
    check("R1 ce3_n high deselects", 1'b0, '0);
    start_c(8'h20); as_read(); cyc();
    check("R1 deselect cycles wrote nothing", 1'b1, ref_mem[8'h20]);
    quiet(); as_write(36'h0CCCCCCCC, 0, 1, 4'hF); cyc();
    check("R1 ce1_n high with strobe C deselects", 1'b0, '0);
    go_on(0); as_read(); cyc();
    check("R1 burst ended by deselect", 1'b0, '0);
    start_c(8'h20); as_read(); cyc();
    check("R1 ce1_n deselect wrote nothing", 1'b1, ref_mem[8'h20]);
    quiet(); cyc();
  endtask

  task automatic t_oe();
    oe_n = 1;
    start_c(8'h20); as_read(); cyc();
    check("R11 oe_n high blocks read drive", 1'b0, '0);
    oe_n = 0; #1;
    check("R11 oe_n low passes active read", 1'b1, ref_mem[8'h20]);
    oe_n = 1; #1;
    check("R11 oe_n high releases at once", 1'b0, '0);
    oe_n = 0;
    start_c(8'h60); as_write(pat(30), 0, 1, 4'hF); cyc(); ref_write(8'h60, pat(30), 0, 1, 4'hF);
    check("R11 oe_n low does not drive a write", 1'b0, '0);
    quiet(); cyc();
  endtask

  task automatic t_pipe();
    quiet(); cyc();
    pipe_mode = 1;
    quiet(); cyc();
    start_c(8'h20); as_read(); cyc();
    check("R10 no data in capture slot", 1'b0, '0);
    start_c(8'h40); cyc();
    check("R10 data one cycle later", 1'b1, ref_mem[8'h20]);
    quiet(); cyc();
    check("R10 read before deselect still shown", 1'b1, ref_mem[8'h40]);
    quiet(); cyc();
    check("R10 deselect slot released", 1'b0, '0);
    start_p(8'h35); as_read(); cyc();
    for (int i = 1; i < 4; i++) begin
      go_on(0); cyc();
      check("R10 R6 pipelined burst", 1'b1, ref_mem[seq(8'h35, i - 1, 1)]);
    end
    quiet(); cyc();
    check("R10 pipelined burst last beat", 1'b1, ref_mem[seq(8'h35, 3, 1)]);
    quiet(); cyc();
    check("R10 released after burst", 1'b0, '0);
    start_c(8'h61); as_write(pat(31), 0, 1, 4'hF); cyc(); ref_write(8'h61, pat(31), 0, 1, 4'hF);
    quiet(); cyc();
    check("R8 R10 write leaves pipelined slot empty", 1'b0, '0);
    start_c(8'h61); as_read(); cyc();
    quiet(); cyc();
    check("R10 pipelined read of new write", 1'b1, ref_mem[8'h61]);
    quiet(); cyc();
    pipe_mode = 0;
  endtask

  task automatic t_sleep();
    start_c(8'h40); as_read(); cyc();
    check("R9 read before sleep", 1'b1, ref_mem[8'h40]);
    sleep = 1; #1;
    check("R12 sleep releases outputs at once", 1'b0, '0);
    start_c(8'h20); as_write(36'h0EEEEEEEE, 0, 1, 4'hF); cyc();
    check("R12 no output in sleep", 1'b0, '0);
    go_on(0); as_read(); cyc();
    check("R12 no read in sleep", 1'b0, '0);
    sleep = 0;
    go_on(0); cyc();
    check("R12 burst counter held over sleep", 1'b1, ref_mem[8'h41]);
    start_c(8'h20); cyc();
    check("R12 contents kept, sleep wrote nothing", 1'b1, ref_mem[8'h20]);
    quiet(); cyc();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    rst_n = 0; oe_n = 0; pipe_mode = 0; lin_order_n = 0; sleep = 0;
    quiet();
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_single();
    t_linear_burst();
    t_interleave();
    t_bytes();
    t_suspend();
    t_strobe_mask();
    t_oe();
    t_pipe();
    t_sleep();
    finish_run();
  end

  initial begin
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: en=%b data=%h expected en=x data=run complete", dout_en, dout);
    finish_run();
  end

endmodule